// File: doc/BRIEF.md
# Shared Segment Allocator for Cache and Vector Registers

This block owns a fixed pool of equal-sized storage segments. Each segment is either in use by the cache or held by one architectural vector register. After reset every segment is cache storage and no register holds anything. The first write to a register that has no storage makes the allocator pick segments for it. The number of segments comes from the currently configured vector width. Each picked segment is handed to the cache for eviction, and the register receives the segments only after the cache has acknowledged every eviction.

A bulk release hint tells the allocator that no vector register holds live data. On that hint every segment goes back to the cache. The writing instruction sees a valid/ready handshake and is stalled while evictions are outstanding. A demand the pool cannot meet is rejected with an error flag. The outputs are the segment ownership bits and, for each register, its segment count and ordered segment list. The rest of the cache and the vector datapath read these outputs.

Top module: `seg_alloc_top`

## Requirements
- R1: In the first cycle after reset is released, `seg_owned` and `reg_valid` are all zero, every count and map field is zero, and `evict_valid`, `wr_ready` and `wr_err` are low.
- R2: A write to a register whose `reg_valid` bit is 0, with a legal demand, starts an allocation one cycle later. In that allocation `evict_valid` rises once for each needed segment. The segments are the lowest-indexed segments that are not owned, presented in ascending order. Each one is held until the cycle in which `evict_ack` is high.
- R3: In the cycle after the last eviction acknowledge, `wr_ready` is high and `wr_err` is low. After that edge the register's valid bit is 1. Its count field (3 bits per register, register r at bits [3r+2:3r]) holds the demand. Its map slots hold the chosen segment indices in ascending order: 4 bits per slot, slot k of register r at bit offset (4r+k)*4. Unused slots read 0. The owner bit of each chosen segment is 1.
- R4: A write to a register whose valid bit is already 1 is accepted in the same cycle with `wr_err` low. It causes no eviction and no change to any output state.
- R5: If the demand exceeds the number of unowned segments, `wr_ready` and `wr_err` are both high in the same cycle. Nothing is evicted or allocated.
- R6: A demand (`cfg_segs`) of 0 or greater than 4 is rejected in the same way as R5.
- R7: A release hint while no allocation is in progress clears every owner bit, valid bit, count and map slot at the next edge. A write presented in that same cycle is not accepted in that cycle.
- R8: A release hint while an allocation is in progress has no effect.
- R9: The demand is sampled when the allocation starts. Later changes to `cfg_segs` do not change the allocation in progress.
- R10: While `evict_valid` is high, `evict_seg` names a segment whose owner bit is 0 and stays stable until acknowledged.
- R11: From the start of an allocation until the cycle of its last acknowledge, `wr_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_segs | input | 3 | Segments per register under the current vector width |
| wr_valid | input | 1 | A vector register write is presented |
| wr_reg | input | 3 | Destination register of the write |
| wr_ready | output | 1 | Write accepted (pass-through, grant or rejection) |
| wr_err | output | 1 | Demand could not be met; nothing allocated |
| evict_valid | output | 1 | Eviction request for `evict_seg` |
| evict_seg | output | 4 | Segment the cache must vacate |
| evict_ack | input | 1 | Cache has vacated `evict_seg` |
| release_hint | input | 1 | No register holds live data; return all segments |
| seg_owned | output | 16 | One bit per segment, 1 when a register holds it |
| reg_valid | output | 8 | One bit per register, 1 when it holds segments |
| reg_seg_cnt | output | 24 | Per-register segment count, 3 bits each |
| reg_seg_map | output | 128 | Per-register list of 4 segment indices, 4 bits each |

## Verification
The bench targets the lowest-free-first ordering after earlier allocations have left holes. A picker that scanned in the wrong direction, or that skipped owned segments incorrectly, would present the wrong `evict_seg` or record a wrong map. It drives a demand exactly equal to the remaining free count and one just above it. An off-by-one in the pool check would then either strand a write or hand out segments that are already owned. It changes `cfg_segs` and pulses the release hint in the middle of an allocation. A design that read the width live, or released while busy, would end with a wrong count or a register that loses its segments. It also presents a release and a write in the same cycle, which exposes any design that lets the write through ahead of the clear.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_GRANT = 2'd2
    } alloc_phase_e;

    // A demand is unusable when it is zero, above the per-register cap,
    // or larger than what the pool still has free.
    function automatic logic demand_bad(input int unsigned need,
                                        input int unsigned cap,
                                        input int unsigned avail);
        return (need == 0) || (need > cap) || (need > avail);
    endfunction

endpackage

// File: rtl/seg_free_picker.sv
module seg_free_picker
    import seg_alloc_pkg::*;
#(
    parameter int NUM_SEGS = 16,
    parameter int MAX_PER  = 4,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int IDX_W   = (MAX_PER > 1) ? $clog2(MAX_PER) : 1,
    localparam int FREE_W  = $clog2(NUM_SEGS + 1)
) (
    input  logic [NUM_SEGS-1:0]             seg_owned,
    output logic [MAX_PER-1:0][SEG_W-1:0]   pick,
    output logic [FREE_W-1:0]               free_cnt
);

    // Ascending scan: the k-th unowned segment lands in slot k.
    always_comb begin
        int n;
        n    = 0;
        pick = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (!seg_owned[i]) begin
                if (n < MAX_PER) begin
                    pick[IDX_W'(n)] = SEG_W'(i);
                end
                n++;
            end
        end
        free_cnt = FREE_W'(n);
    end

endmodule

// File: rtl/seg_alloc_ctrl.sv
module seg_alloc_ctrl
    import seg_alloc_pkg::*;
#(
    parameter int NUM_SEGS = 16,
    parameter int NUM_REGS = 8,
    parameter int MAX_PER  = 4,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(MAX_PER + 1),
    localparam int IDX_W   = (MAX_PER > 1) ? $clog2(MAX_PER) : 1,
    localparam int FREE_W  = $clog2(NUM_SEGS + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_valid,
    input  logic [REG_W-1:0]                wr_reg,
    input  logic                            reg_hit,
    input  logic [CNT_W-1:0]                cfg_segs,
    input  logic [FREE_W-1:0]               free_cnt,
    input  logic [MAX_PER-1:0][SEG_W-1:0]   pick,
    input  logic                            evict_ack,
    input  logic                            release_hint,
    output alloc_phase_e                    phase,
    output logic                            wr_ready,
    output logic                            wr_err,
    output logic                            evict_valid,
    output logic [SEG_W-1:0]                evict_seg,
    output logic                            commit,
    output logic [REG_W-1:0]                commit_reg,
    output logic [CNT_W-1:0]                commit_cnt,
    output logic [MAX_PER-1:0][SEG_W-1:0]   commit_list,
    output logic                            clear_all
);

    logic [REG_W-1:0]              pend_reg;
    logic [CNT_W-1:0]              pend_cnt;
    logic [MAX_PER-1:0][SEG_W-1:0] pend_list;
    logic [IDX_W-1:0]              idx;

    logic idle_req;
    logic bad_dem;
    logic start;
    logic last_ack;

    always_comb begin
        idle_req  = (phase == PH_IDLE) && wr_valid && !release_hint;
        bad_dem   = demand_bad(int'(cfg_segs), MAX_PER, int'(free_cnt));
        start     = idle_req && !reg_hit && !bad_dem;
        wr_err    = idle_req && !reg_hit && bad_dem;
        wr_ready  = (idle_req && (reg_hit || bad_dem)) || (phase == PH_GRANT);
        clear_all = (phase == PH_IDLE) && release_hint;
        evict_valid = (phase == PH_EVICT);
        evict_seg   = pend_list[idx];
        last_ack    = evict_ack && ((int'(idx) + 1) == int'(pend_cnt));
        commit      = (phase == PH_GRANT);
        commit_reg  = pend_reg;
        commit_cnt  = pend_cnt;
        commit_list = pend_list;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pend_reg  <= '0;
            pend_cnt  <= '0;
            pend_list <= '0;
            idx       <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_EVICT;
                        pend_reg <= wr_reg;
                        pend_cnt <= cfg_segs;
                        idx      <= '0;
                        for (int k = 0; k < MAX_PER; k++) begin
                            pend_list[k] <= (k < int'(cfg_segs)) ? pick[k] : '0;
                        end
                    end
                end
                PH_EVICT: begin
                    if (last_ack) begin
                        phase <= PH_GRANT;
                    end else if (evict_ack) begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_GRANT: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg_map_store.sv
module seg_map_store
    import seg_alloc_pkg::*;
#(
    parameter int NUM_SEGS = 16,
    parameter int NUM_REGS = 8,
    parameter int MAX_PER  = 4,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(MAX_PER + 1)
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        commit,
    input  logic [REG_W-1:0]                            commit_reg,
    input  logic [CNT_W-1:0]                            commit_cnt,
    input  logic [MAX_PER-1:0][SEG_W-1:0]               commit_list,
    input  logic                                        clear_all,
    output logic [NUM_SEGS-1:0]                         seg_owned,
    output logic [NUM_REGS-1:0]                         reg_valid,
    output logic [NUM_REGS-1:0][CNT_W-1:0]              reg_cnt,
    output logic [NUM_REGS-1:0][MAX_PER-1:0][SEG_W-1:0] reg_map
);

    // Owner bits: set per chosen slot on commit, cleared in bulk.
    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            seg_owned <= '0;
        end else if (commit) begin
            for (int k = 0; k < MAX_PER; k++) begin
                if (k < int'(commit_cnt)) begin
                    seg_owned[commit_list[k]] <= 1'b1;
                end
            end
        end
    end

    // One entry per architectural register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                reg_valid[g] <= 1'b0;
                reg_cnt[g]   <= '0;
                reg_map[g]   <= '0;
            end else if (commit && (commit_reg == REG_W'(g))) begin
                reg_valid[g] <= 1'b1;
                reg_cnt[g]   <= commit_cnt;
                reg_map[g]   <= commit_list;
            end
        end
    end

endmodule

// File: rtl/seg_alloc_top.sv
module seg_alloc_top
    import seg_alloc_pkg::*;
#(
    parameter int NUM_SEGS = 16,
    parameter int NUM_REGS = 8,
    parameter int MAX_PER  = 4,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(MAX_PER + 1),
    localparam int FREE_W  = $clog2(NUM_SEGS + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [CNT_W-1:0]                    cfg_segs,
    input  logic                                wr_valid,
    input  logic [REG_W-1:0]                    wr_reg,
    output logic                                wr_ready,
    output logic                                wr_err,
    output logic                                evict_valid,
    output logic [SEG_W-1:0]                    evict_seg,
    input  logic                                evict_ack,
    input  logic                                release_hint,
    output logic [NUM_SEGS-1:0]                 seg_owned,
    output logic [NUM_REGS-1:0]                 reg_valid,
    output logic [NUM_REGS*CNT_W-1:0]           reg_seg_cnt,
    output logic [NUM_REGS*MAX_PER*SEG_W-1:0]   reg_seg_map
);

    logic [MAX_PER-1:0][SEG_W-1:0]               pick;
    logic [FREE_W-1:0]                           free_cnt;
    alloc_phase_e                                phase;
    logic                                        commit;
    logic [REG_W-1:0]                            commit_reg;
    logic [CNT_W-1:0]                            commit_cnt;
    logic [MAX_PER-1:0][SEG_W-1:0]               commit_list;
    logic                                        clear_all;
    logic [NUM_REGS-1:0][CNT_W-1:0]              reg_cnt;
    logic [NUM_REGS-1:0][MAX_PER-1:0][SEG_W-1:0] reg_map;
    logic                                        reg_hit;
    logic                                        busy;

    assign reg_hit     = reg_valid[wr_reg];
    assign busy        = (phase != PH_IDLE);
    assign reg_seg_cnt = reg_cnt;
    assign reg_seg_map = reg_map;

    seg_free_picker #(
        .NUM_SEGS (NUM_SEGS),
        .MAX_PER  (MAX_PER)
    ) u_picker (
        .seg_owned (seg_owned),
        .pick      (pick),
        .free_cnt  (free_cnt)
    );

    seg_alloc_ctrl #(
        .NUM_SEGS (NUM_SEGS),
        .NUM_REGS (NUM_REGS),
        .MAX_PER  (MAX_PER)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_valid     (wr_valid),
        .wr_reg       (wr_reg),
        .reg_hit      (reg_hit),
        .cfg_segs     (cfg_segs),
        .free_cnt     (free_cnt),
        .pick         (pick),
        .evict_ack    (evict_ack),
        .release_hint (release_hint),
        .phase        (phase),
        .wr_ready     (wr_ready),
        .wr_err       (wr_err),
        .evict_valid  (evict_valid),
        .evict_seg    (evict_seg),
        .commit       (commit),
        .commit_reg   (commit_reg),
        .commit_cnt   (commit_cnt),
        .commit_list  (commit_list),
        .clear_all    (clear_all)
    );

    seg_map_store #(
        .NUM_SEGS (NUM_SEGS),
        .NUM_REGS (NUM_REGS),
        .MAX_PER  (MAX_PER)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_reg  (commit_reg),
        .commit_cnt  (commit_cnt),
        .commit_list (commit_list),
        .clear_all   (clear_all),
        .seg_owned   (seg_owned),
        .reg_valid   (reg_valid),
        .reg_cnt     (reg_cnt),
        .reg_map     (reg_map)
    );

endmodule

// File: rtl/seg_alloc_chk.sv
module seg_alloc_chk #(
    parameter int NUM_SEGS = 16,
    parameter int NUM_REGS = 8,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_valid,
    input logic [REG_W-1:0]    wr_reg,
    input logic                wr_ready,
    input logic                wr_err,
    input logic                evict_valid,
    input logic [SEG_W-1:0]    evict_seg,
    input logic                evict_ack,
    input logic                release_hint,
    input logic [NUM_SEGS-1:0] seg_owned,
    input logic [NUM_REGS-1:0] reg_valid,
    input logic                busy
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seg_owned == '0 && reg_valid == '0 && !evict_valid));

    // R10
    evict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && !evict_ack) |=> (evict_valid && $stable(evict_seg)));

    // R10
    evict_free_chk: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> !seg_owned[evict_seg]);

    // R5
    err_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> wr_ready);

    // R5
    err_noop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> ($stable(seg_owned) && $stable(reg_valid) && !evict_valid));

    // R7
    release_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (release_hint && !busy) |=> (seg_owned == '0 && reg_valid == '0));

    // R8
    release_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (release_hint && evict_valid) |=> $stable(reg_valid));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> !wr_ready);

    // R3
    grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && !wr_err && busy) |=> reg_valid[$past(wr_reg)]);

endmodule

bind seg_alloc_top seg_alloc_chk #(
    .NUM_SEGS (NUM_SEGS),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_reg       (wr_reg),
    .wr_ready     (wr_ready),
    .wr_err       (wr_err),
    .evict_valid  (evict_valid),
    .evict_seg    (evict_seg),
    .evict_ack    (evict_ack),
    .release_hint (release_hint),
    .seg_owned    (seg_owned),
    .reg_valid    (reg_valid),
    .busy         (busy)
);

// File: tb/seg_alloc_top_bench.sv
module seg_alloc_top_bench;

    localparam int NS = 16;
    localparam int NR = 8;
    localparam int MP = 4;
    localparam int SW = 4;
    localparam int RW = 3;
    localparam int CW = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CW-1:0]    cfg_segs = '0;
    logic             wr_valid = 1'b0;
    logic [RW-1:0]    wr_reg = '0;
    logic             wr_ready;
    logic             wr_err;
    logic             evict_valid;
    logic [SW-1:0]    evict_seg;
    logic             evict_ack = 1'b0;
    logic             release_hint = 1'b0;
    logic [NS-1:0]    seg_owned;
    logic [NR-1:0]    reg_valid;
    logic [NR*CW-1:0] reg_seg_cnt;
    logic [NR*MP*SW-1:0] reg_seg_map;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ack_lat = 0;
    int ack_wait = 0;

    // reference model state
    bit mown [NS];
    bit mval [NR];
    int mcnt [NR];
    int mmap [NR][MP];
    int mph = 0;
    int mpend [$];
    int midx = 0;
    int mreg = 0;
    int mneed = 0;

    seg_alloc_top u_seg_alloc_top (
        .clk (clk), .rst (rst), .cfg_segs (cfg_segs),
        .wr_valid (wr_valid), .wr_reg (wr_reg), .wr_ready (wr_ready),
        .wr_err (wr_err), .evict_valid (evict_valid), .evict_seg (evict_seg),
        .evict_ack (evict_ack), .release_hint (release_hint),
        .seg_owned (seg_owned), .reg_valid (reg_valid),
        .reg_seg_cnt (reg_seg_cnt), .reg_seg_map (reg_seg_map)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: act=%0d exp=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < NS; s++) mown[s] = 1'b0;
        for (int r = 0; r < NR; r++) begin
            mval[r] = 1'b0;
            mcnt[r] = 0;
            for (int k = 0; k < MP; k++) mmap[r][k] = 0;
        end
    endtask

    // Compare on every falling edge, then step the model past the next rise.
    always @(negedge clk) begin
        if (rst) begin
            model_clear();
            mph = 0;
            midx = 0;
        end else begin
            int free_n;
            bit idle_req, hit, bad, e_err, e_rdy, e_ev;
            free_n = 0;
            for (int s = 0; s < NS; s++) if (!mown[s]) free_n++;
            idle_req = (mph == 0) && wr_valid && !release_hint;
            hit = mval[wr_reg];
            bad = (cfg_segs == 0) || (cfg_segs > MP) || (int'(cfg_segs) > free_n);
            e_err = idle_req && !hit && bad;
            e_rdy = (idle_req && (hit || bad)) || (mph == 2);
            e_ev = (mph == 1);
            chk(evict_valid == e_ev, "R2", "evict_valid", evict_valid, e_ev);
            // R10: the named segment matches the model while the request is held
            if (e_ev) chk(int'(evict_seg) == mpend[midx], "R2", "evict_seg", evict_seg, mpend[midx]);
            chk(wr_ready == e_rdy, "R11", "wr_ready", wr_ready, e_rdy);
            chk(wr_err == e_err, "R5", "wr_err", wr_err, e_err);
            for (int s = 0; s < NS; s++)
                chk(seg_owned[s] == mown[s], "R3", "seg_owned bit", seg_owned[s], mown[s]);
            for (int r = 0; r < NR; r++) begin
                chk(reg_valid[r] == mval[r], "R3", "reg_valid bit", reg_valid[r], mval[r]);
                chk(int'(reg_seg_cnt[r*CW +: CW]) == mcnt[r], "R3", "reg count",
                    reg_seg_cnt[r*CW +: CW], mcnt[r]);
                for (int k = 0; k < MP; k++)
                    chk(int'(reg_seg_map[(r*MP+k)*SW +: SW]) == mmap[r][k], "R3", "map slot",
                        reg_seg_map[(r*MP+k)*SW +: SW], mmap[r][k]);
            end
            // advance
            case (mph)
                0: begin
                    if (release_hint) model_clear();
                    else if (idle_req && !hit && !bad) begin
                        mpend.delete();
                        for (int s = 0; s < NS; s++)
                            if (!mown[s] && mpend.size() < int'(cfg_segs)) mpend.push_back(s);
                        mneed = int'(cfg_segs);
                        mreg = int'(wr_reg);
                        midx = 0;
                        mph = 1;
                    end
                end
                1: begin
                    if (evict_ack) begin
                        if (midx == mneed - 1) mph = 2;
                        else midx++;
                    end
                end
                default: begin
                    mval[mreg] = 1'b1;
                    mcnt[mreg] = mneed;
                    for (int k = 0; k < MP; k++) mmap[mreg][k] = (k < mneed) ? mpend[k] : 0;
                    for (int k = 0; k < mneed; k++) mown[mpend[k]] = 1'b1;
                    mph = 0;
                end
            endcase
        end
    end

    // Cache side: acknowledge after ack_lat waiting cycles.
    always @(posedge clk) begin
        #1;
        if (evict_ack) begin
            evict_ack = 1'b0;
            ack_wait = 0;
        end else if (evict_valid) begin
            if (ack_wait >= ack_lat) evict_ack = 1'b1;
            else ack_wait++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            failures++;
            $display("FAIL R11 watchdog: act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_write(input int r, input int c, output bit err);
        @(posedge clk); #1;
        wr_valid = 1'b1;
        wr_reg = RW'(r);
        cfg_segs = CW'(c);
        do @(negedge clk); while (!wr_ready);
        err = wr_err;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    function automatic int slot(input int r, input int k);
        return int'(reg_seg_map[(r*MP+k)*SW +: SW]);
    endfunction

    initial begin
        bit e;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk(seg_owned == '0, "R1", "owned after reset", seg_owned, 0);
        chk(reg_valid == '0 && !evict_valid && !wr_ready, "R1", "idle after reset", reg_valid, 0);

        ack_lat = 0;
        do_write(1, 4, e);
        chk(slot(1, 0) == 0 && slot(1, 3) == 3, "R3", "r1 slots", slot(1, 3), 3);

        // R4: second write to the same register passes through
        do_write(1, 2, e);
        @(negedge clk);
        chk(!e && reg_seg_cnt[1*CW +: CW] == 4, "R4", "pass-through count", reg_seg_cnt[1*CW +: CW], 4);

        ack_lat = 2;
        do_write(2, 2, e);
        chk(slot(2, 0) == 4 && slot(2, 1) == 5 && slot(2, 2) == 0, "R2", "r2 ascending", slot(2, 1), 5);

        // R9 and R8: width change and release while evicting
        ack_lat = 3;
        fork
            do_write(3, 3, e);
            begin
                repeat (3) @(posedge clk);
                #1 cfg_segs = 3'd1;
                release_hint = 1'b1;
                @(posedge clk); #1 release_hint = 1'b0;
            end
        join
        @(negedge clk);
        chk(reg_seg_cnt[3*CW +: CW] == 3, "R9", "sampled width", reg_seg_cnt[3*CW +: CW], 3);
        chk(reg_valid[1] && reg_valid[2], "R8", "release ignored", reg_valid, 3'b110);

        ack_lat = 1;
        do_write(4, 4, e);               // segments 9..12, 3 free remain
        do_write(5, 4, e);               // one above the free count
        chk(e == 1'b1 && !reg_valid[5], "R5", "overflow rejected", e, 1);
        do_write(5, 3, e);               // exactly the free count
        chk(!e && slot(5, 2) == 15, "R5", "exact fit", slot(5, 2), 15);

        do_write(6, 0, e);
        chk(e == 1'b1, "R6", "zero demand", e, 1);
        do_write(6, 5, e);
        chk(e == 1'b1 && !reg_valid[6], "R6", "demand above cap", e, 1);

        // R7: release with a write in the same cycle
        @(posedge clk); #1;
        release_hint = 1'b1;
        wr_valid = 1'b1; wr_reg = 3'd6; cfg_segs = 3'd2;
        @(negedge clk);
        chk(!wr_ready, "R7", "write held during release", wr_ready, 0);
        @(posedge clk); #1 release_hint = 1'b0;
        @(negedge clk);
        chk(seg_owned == '0 && reg_valid == '0, "R7", "all released", seg_owned, 0);
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(slot(6, 0) == 0 && slot(6, 1) == 1, "R7", "realloc from zero", slot(6, 1), 1);

        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            ack_lat = $urandom_range(0, 3);
            if ($urandom_range(0, 9) == 0) begin
                @(posedge clk); #1 release_hint = 1'b1;
                @(posedge clk); #1 release_hint = 1'b0;
            end else begin
                do_write($urandom_range(0, NR-1), $urandom_range(0, 5), e);
            end
        end

        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule